// File: doc/BRIEF.md
# CPU Bank Address Translator

This block turns a 16-bit CPU write address in the upper half of the CPU map ($6000-$FFFF) into a physical flash byte address. It can also steer the write to work RAM instead of flash. The lower region, $6000-$7FFF, is split by a RAM-region window mode into one 8K window or two 4K windows. The upper region, $8000-$FFFF, is split by a ROM-region window mode into one 32K window, two 16K windows, a 16K window plus two 8K windows, four 8K windows, or eight 4K windows.

Each window is steered by one 16-bit bank register from a file of ten registers. The low 15 bits of the register give the bank number. Its top bits, when set, send every write in that window to RAM. A boot flag pins the upper region to the four-8K layout, whatever mode is programmed.

The flash command sequencer sits downstream and takes the registered address and the flash strobe. The RAM controller takes the RAM strobe and the CPU address.

Top module: `cpu_bank_xlate`

## Requirements
- R1: A write with address below 0x6000 is ignored: neither `flash_we` nor `ram_we` pulses and `flash_addr` keeps its value.
- R2: Each accepted write (`cpu_wr` high, address 0x6000 or above) is followed, one clock after the edge that samples it, by exactly one of `flash_we`/`ram_we` for one cycle. With `cpu_wr` low, neither strobe is set.
- R3: With `ram_mode`=0, $6000-$7FFF is one window driven by register 1. If bit 15 of that register is 1, the write goes to RAM. Otherwise the flash address is (reg[14:0] << 13) | addr[12:0].
- R4: With `ram_mode`=1, $6000-$6FFF uses register 1 and $7000-$7FFF uses register 2. The RAM rule and the address formula are the same as in R3.
- R5: In $8000-$FFFF, a selected register with bits [15:14] not 00 sends the write to RAM.
- R6: `rom_mode`=0: register 3 drives the whole region, and flash = (reg[14:0] << 15) | addr[14:0].
- R7: `rom_mode`=1: register 3 drives $8000-$BFFF and register 7 drives $C000-$FFFF, and flash = (reg[14:0] << 14) | addr[13:0].
- R8: `rom_mode`=2: $8000-$BFFF uses register 3 with flash = (reg[5:0] << 14) | addr[13:0]. $C000-$DFFF uses register 7 and $E000-$FFFF uses register 9, with flash = (reg[14:0] << 13) | addr[12:0].
- R9: `rom_mode`=3: the 8K windows from $8000 up use registers 3, 5, 7 and 9 in turn, and flash = (reg[14:0] << 13) | addr[12:0].
- R10: `rom_mode`=4: the 4K windows from $8000 up use registers 3 to 10 in turn, and flash = (reg[14:0] << 12) | addr[11:0].
- R11: While `boot_rom` is 1, the upper region behaves as `rom_mode`=3, whatever value `rom_mode` holds.
- R12: With `boot_rom`=0, a `rom_mode` value of 5, 6 or 7 sends every upper-region write to RAM.
- R13: Reset clears both strobes and `flash_addr`. `flash_addr` changes only on the cycle where `flash_we` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ram_mode | input | 1 | RAM-region window mode (0: one 8K, 1: two 4K) |
| rom_mode | input | 3 | ROM-region window mode, 0 to 4 defined |
| boot_rom | input | 1 | Forces the upper region to the four-8K layout |
| bank_regs | input | 160 | Bank registers 1 to 10; register k sits at bits [16(k-1)+15 : 16(k-1)] |
| flash_addr | output | 30 | Translated flash byte address, held between flash writes |
| flash_we | output | 1 | Flash-write pulse |
| ram_we | output | 1 | RAM-write pulse |

## Verification
Every result of this block is due exactly one clock after the edge that samples the write: both strobes and the flash address come out of the same register stage. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares all three outputs at the next falling edge against a behavioural model evaluated on the stimulus that was just applied. No check waits on a handshake. Between flash writes the model keeps the last expected flash address, so a change in `flash_addr` on a RAM-write, ignored-write or idle cycle is caught on that same cycle.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [2:0] {
    ROM_1X32K     = 3'd0,
    ROM_2X16K     = 3'd1,
    ROM_16K_2X8K  = 3'd2,
    ROM_4X8K      = 3'd3,
    ROM_8X4K      = 3'd4
  } rom_mode_e;

  typedef enum logic {
    RAM_1X8K = 1'b0,
    RAM_2X4K = 1'b1
  } ram_mode_e;

  // width of the bank-number field kept for the narrow 16K window
  localparam int unsigned NARROW_BANK_W = 6;
endpackage

// File: rtl/cbt_ram_window.sv
// Decode of the $6000-$7FFF region: picks one of two bank registers and
// forms the 8K-granular flash address.
module cbt_ram_window #(
  parameter int unsigned BW  = 16,
  parameter int unsigned FAW = 30,
  parameter int unsigned OFS = 13
) (
  input  logic [OFS-1:0] addr_lo,
  input  logic           ram_mode,
  input  logic [BW-1:0]  bank_a,
  input  logic [BW-1:0]  bank_b,
  output logic           to_ram,
  output logic [FAW-1:0] faddr
);
  import cbt_pkg::*;

  logic [BW-1:0] bank;

  always_comb begin
    if (ram_mode_e'(ram_mode) == RAM_2X4K && addr_lo[OFS-1])
      bank = bank_b;
    else
      bank = bank_a;
    to_ram = bank[BW-1];
    faddr  = (FAW'(bank[BW-2:0]) << OFS) | FAW'(addr_lo);
  end
endmodule

// File: rtl/cbt_rom_window.sv
// Decode of the $8000-$FFFF region across all window granularities.
module cbt_rom_window #(
  parameter int unsigned BW    = 16,
  parameter int unsigned FAW   = 30,
  parameter int unsigned OW    = 15,
  parameter int unsigned NWIN  = 8,
  localparam int unsigned SW   = $clog2(NWIN),
  localparam int unsigned SHW  = $clog2(FAW)
) (
  input  logic [OW-1:0]  addr_off,
  input  logic [2:0]     rom_mode,
  input  logic           boot_rom,
  input  logic [BW-1:0]  regs [NWIN],
  output logic           to_ram,
  output logic [FAW-1:0] faddr
);
  import cbt_pkg::*;

  rom_mode_e     eff;
  logic [SW-1:0] sel;
  logic [SHW-1:0] shift;
  logic          narrow;
  logic          bad;
  logic [BW-1:0] bank;
  logic [BW-2:0] bank_num;
  logic [FAW-1:0] ofs_mask;

  always_comb begin
    eff    = boot_rom ? ROM_4X8K : rom_mode_e'(rom_mode);
    sel    = '0;
    shift  = SHW'(OW);
    narrow = 1'b0;
    bad    = 1'b0;
    case (eff)
      ROM_1X32K: begin
        sel   = '0;
        shift = SHW'(OW);
      end
      ROM_2X16K: begin
        sel   = addr_off[OW-1] ? SW'(4) : SW'(0);
        shift = SHW'(OW - 1);
      end
      ROM_16K_2X8K: begin
        if (!addr_off[OW-1]) begin
          sel    = '0;
          shift  = SHW'(OW - 1);
          narrow = 1'b1;
        end else begin
          sel   = {addr_off[OW-1:OW-2], 1'b0};
          shift = SHW'(OW - 2);
        end
      end
      ROM_4X8K: begin
        sel   = {addr_off[OW-1:OW-2], 1'b0};
        shift = SHW'(OW - 2);
      end
      ROM_8X4K: begin
        sel   = addr_off[OW-1:OW-3];
        shift = SHW'(OW - 3);
      end
      default: bad = 1'b1;
    endcase

    bank     = regs[sel];
    bank_num = '0;
    if (narrow)
      bank_num[NARROW_BANK_W-1:0] = bank[NARROW_BANK_W-1:0];
    else
      bank_num = bank[BW-2:0];

    to_ram   = bad | (|bank[BW-1:BW-2]);
    ofs_mask = (FAW'(1) << shift) - FAW'(1);
    faddr    = (FAW'(bank_num) << shift) | (FAW'(addr_off) & ofs_mask);
  end
endmodule

// File: rtl/cpu_bank_xlate.sv
module cpu_bank_xlate #(
  parameter int unsigned AW    = 16,
  parameter int unsigned BW    = 16,
  parameter int unsigned NREG  = 10,
  parameter int unsigned FAW   = 30,
  localparam int unsigned RAM_OFS  = AW - 3,
  localparam int unsigned ROM_OW   = AW - 1,
  localparam int unsigned ROM_BASE = 2,
  localparam int unsigned NWIN     = NREG - ROM_BASE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        cpu_addr,
  input  logic                 cpu_wr,
  input  logic                 ram_mode,
  input  logic [2:0]           rom_mode,
  input  logic                 boot_rom,
  input  logic [NREG*BW-1:0]   bank_regs,
  output logic [FAW-1:0]       flash_addr,
  output logic                 flash_we,
  output logic                 ram_we
);
  // rf[k] holds bank register k+1
  logic [BW-1:0] rf       [NREG];
  logic [BW-1:0] rom_regs [NWIN];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign rf[k] = bank_regs[k*BW +: BW];
  end
  for (genvar j = 0; j < NWIN; j++) begin : g_rom_regs
    assign rom_regs[j] = rf[j + ROM_BASE];
  end

  logic           ram_to_ram, rom_to_ram;
  logic [FAW-1:0] ram_faddr, rom_faddr;

  cbt_ram_window #(.BW(BW), .FAW(FAW), .OFS(RAM_OFS)) u_ram_win (
    .addr_lo  (cpu_addr[RAM_OFS-1:0]),
    .ram_mode (ram_mode),
    .bank_a   (rf[0]),
    .bank_b   (rf[1]),
    .to_ram   (ram_to_ram),
    .faddr    (ram_faddr)
  );

  cbt_rom_window #(.BW(BW), .FAW(FAW), .OW(ROM_OW), .NWIN(NWIN)) u_rom_win (
    .addr_off (cpu_addr[ROM_OW-1:0]),
    .rom_mode (rom_mode),
    .boot_rom (boot_rom),
    .regs     (rom_regs),
    .to_ram   (rom_to_ram),
    .faddr    (rom_faddr)
  );

  logic           in_low, in_high, accept, sel_ram;
  logic [FAW-1:0] sel_faddr;

  always_comb begin
    in_high   = cpu_addr[AW-1];
    in_low    = (cpu_addr[AW-1:AW-3] == 3'b011);
    accept    = cpu_wr & (in_low | in_high);
    sel_ram   = in_high ? rom_to_ram : ram_to_ram;
    sel_faddr = in_high ? rom_faddr  : ram_faddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_we   <= 1'b0;
      ram_we     <= 1'b0;
      flash_addr <= '0;
    end else begin
      flash_we <= accept & ~sel_ram;
      ram_we   <= accept & sel_ram;
      if (accept & ~sel_ram)
        flash_addr <= sel_faddr;
    end
  end

  // ---------------- assertions ----------------
  assert_ignore_low_R1: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr < AW'(16'h6000)) |=> (!flash_we && !ram_we));

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr >= AW'(16'h6000)) |=> (flash_we ^ ram_we));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> (!flash_we && !ram_we));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flash_we, ram_we}));

  assert_low_ram_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_low && !ram_mode && rf[0][BW-1]) |=> ram_we);

  assert_high_ram_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_high && !boot_rom && rom_mode == 3'd0 && (|rf[ROM_BASE][BW-1:BW-2]))
    |=> ram_we);

  assert_undef_mode_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_high && !boot_rom && rom_mode > 3'd4) |=> ram_we);

  assert_addr_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !flash_we |-> $stable(flash_addr));
endmodule

// File: tb/cpu_bank_xlate_tb.sv
module cpu_bank_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        ram_mode = 1'b0;
  logic [2:0]  rom_mode = '0;
  logic        boot_rom = 1'b0;
  logic [159:0] bank_regs;
  logic [29:0] flash_addr;
  logic        flash_we, ram_we;

  logic [15:0] rg [1:10];
  int n_checks = 0;
  int n_fail   = 0;
  int exp_fa   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  always_comb
    for (int k = 1; k <= 10; k++) bank_regs[16*(k-1) +: 16] = rg[k];

  cpu_bank_xlate u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .ram_mode(ram_mode), .rom_mode(rom_mode), .boot_rom(boot_rom),
    .bank_regs(bank_regs), .flash_addr(flash_addr),
    .flash_we(flash_we), .ram_we(ram_we)
  );

  // behavioural reference: kind 0 = none, 1 = flash, 2 = RAM
  task automatic model(output int kind, output int fa, output string req);
    int a, r, size, mask, off, m;
    a = cpu_addr; kind = 0; fa = 0; req = "R2";
    if (!cpu_wr) return;
    if (a < 'h6000) begin req = "R1"; return; end
    if (a < 'h8000) begin
      r   = (ram_mode && a >= 'h7000) ? 2 : 1;
      req = ram_mode ? "R4" : "R3";
      if (rg[r][15]) kind = 2;
      else begin kind = 1; fa = (rg[r] & 'h7fff) * 8192 + (a % 8192); end
      return;
    end
    off = a - 'h8000; m = boot_rom ? 3 : rom_mode; mask = 'h7fff;
    req = boot_rom ? "R11" : (m == 0 ? "R6" : m == 1 ? "R7" : m == 2 ? "R8" :
                              m == 3 ? "R9" : m == 4 ? "R10" : "R12");
    case (m)
      0: begin r = 3; size = 32768; end
      1: begin r = (off < 16384) ? 3 : 7; size = 16384; end
      2: if (off < 16384) begin r = 3; size = 16384; mask = 'h3f; end
         else begin r = (off < 'h6000) ? 7 : 9; size = 8192; end
      3: begin r = 3 + 2 * (off / 8192); size = 8192; end
      4: begin r = 3 + off / 4096; size = 4096; end
      default: begin kind = 2; return; end
    endcase
    if (rg[r][15:14] != 0) begin kind = 2; req = {req, "/R5"}; end
    else begin kind = 1; fa = (rg[r] & mask) * size + (off % size); end
  endtask

  // drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic step(input logic [15:0] a, input logic wr);
    int kind, fa; string req;
    cpu_addr = a; cpu_wr = wr;
    model(kind, fa, req);
    if (kind == 1) exp_fa = fa;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (flash_we !== (kind == 1) || ram_we !== (kind == 2) || flash_addr !== 30'(exp_fa)) begin
      n_fail++;
      $display("FAIL %s addr=%h: got fwe=%b rwe=%b fa=%h, expected fwe=%b rwe=%b fa=%h",
               req, a, flash_we, ram_we, flash_addr, kind == 1, kind == 2, 30'(exp_fa));
    end
  endtask

  initial begin
    for (int k = 1; k <= 10; k++) rg[k] = 16'(k * 16'h0111);
    repeat (3) @(negedge clk);
    // R13: reset state
    n_checks++;
    if (flash_we !== 1'b0 || ram_we !== 1'b0 || flash_addr !== '0) begin
      n_fail++;
      $display("FAIL R13 reset: got %b %b %h expected 0 0 0", flash_we, ram_we, flash_addr);
    end
    rst = 1'b0;

    // R1 and R2: ignored and idle
    step(16'h5fff, 1); step(16'h0000, 1); step(16'h9000, 0);
    // R3: one 8K window, flash then RAM
    ram_mode = 0; rg[1] = 16'h1234; step(16'h6abc, 1); step(16'h7fff, 1);
    rg[1] = 16'h8001; step(16'h6000, 1); step(16'h0100, 0);
    // R4: two 4K windows
    ram_mode = 1; rg[1] = 16'h0022; rg[2] = 16'h0033;
    step(16'h6123, 1); step(16'h7123, 1); rg[2] = 16'h8000; step(16'h7fff, 1);
    // R6 and R5
    rg[3] = 16'h7fff; rom_mode = 0; step(16'h8000, 1); step(16'hffff, 1);
    rg[3] = 16'h4000; step(16'h8123, 1);
    // R7
    rg[3] = 16'h0005; rg[7] = 16'h0109; rom_mode = 1; step(16'hbfff, 1); step(16'hc001, 1);
    // R8: narrow low window and two 8K
    rg[3] = 16'h3fff; rg[9] = 16'h0aaa; rom_mode = 2;
    step(16'h8004, 1); step(16'hd000, 1); step(16'he555, 1);
    // R9
    rg[5] = 16'h0ee5; rom_mode = 3; step(16'ha001, 1); step(16'hfff0, 1);
    // R10
    for (int w = 0; w < 8; w++) rg[3 + w] = 16'(16'h0100 + w);
    rom_mode = 4; for (int w = 0; w < 8; w++) step(16'(16'h8000 + w * 16'h1000 + 7), 1);
    // R11: boot forces four-8K layout
    boot_rom = 1; rom_mode = 4; step(16'h9000, 1); step(16'hb000, 1);
    rom_mode = 7; step(16'hf123, 1); boot_rom = 0;
    // R12: undefined modes
    for (int m = 5; m < 8; m++) begin rom_mode = 3'(m); step(16'h8888, 1); end
    step(16'h6000, 1);

    // randomized traffic across all modes
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0)
        for (int k = 1; k <= 10; k++)
          rg[k] = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom & 'h3fff);
      ram_mode = 1'($urandom);
      rom_mode = 3'($urandom);
      boot_rom = ($urandom % 8 == 0);
      step(16'($urandom), ($urandom % 4) != 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule